// File: doc/BRIEF.md
# Dual-Channel Trigger Timestamp Capture

This block timestamps edges on two asynchronous trigger pins against a free-running 64-bit time bus supplied by a separate time counter. Each pin is brought into the clock domain and passed to an edge detector. A per-channel polarity bit in a control register selects whether a rising or a falling edge counts. When the selected edge arrives, the block stores the whole 64-bit time value in that channel's snapshot register. It also sets a sticky event flag.

Software reaches the block through a small register port with one write strobe and one read strobe. Reads return data combinationally for the address presented in the same cycle, and every access completes in that cycle. The port has no back-pressure. Event flags are cleared by writing ones to them. A mask register selects which flags drive the single interrupt line. Each snapshot is read as two 32-bit words, high word first. Reading the high word freezes a copy of the low word, so the pair stays consistent even if a newer edge overwrites the snapshot between the two reads.

Top module: `trig_stamp_unit`

## Requirements
- R1: After a synchronous reset every readable register reads zero, and `irq` is low.
- R2: A trigger level change first sampled at clock edge k is acted on at edge k+2. At that edge the channel's snapshot loads the `time_now` value present then. The high half (bits 63:32) reads at offset 3 for channel 0 and offset 5 for channel 1.
- R3: Control register (offset 0) bit 8 sets the polarity of channel 0 and bit 9 sets it for channel 1. A value of 0 selects rising edges and 1 selects falling edges. An edge of the other direction changes neither the snapshot nor the flag.
- R4: The event register (offset 1) holds the channel 0 flag at bit 24 and the channel 1 flag at bit 25. A flag stays set until software clears it.
- R5: A write to offset 1 clears each flag whose data bit is 1 and leaves flags under 0 bits unchanged. A flag set by an edge in the same cycle as its clear stays set.
- R6: The mask register (offset 2) uses bits 24 and 25, matching the flags. `irq` is high exactly while some flag and its mask bit are both 1.
- R7: A selected edge that arrives while the channel's flag is still set overwrites the snapshot with the newer time.
- R8: A read strobe at the high-word offset copies the snapshot's low half into a holding word. Offset 4 (channel 0) and offset 6 (channel 1) return that holding word.
- R9: Offset 7 and all register bits not listed above read zero, and writes to those bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 2 | Asynchronous trigger pins, bit 0 is channel 0 |
| time_now | input | 64 | Current time from the time counter |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe (side effect on high-word reads) |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| irq | output | 1 | Masked OR of the event flags |

## Verification
The bench builds the block with its defaults: two channels, a 64-bit time bus and a two-flop synchronizer. This makes both polarity bits, both flag positions and the pairing between the two high/low offsets reachable. The time bus starts just below a low-word rollover, so snapshots taken on both sides of a carry into the high half are compared. A random phase mixes trigger toggles with control, mask and clear writes. This brings a set and a clear on the same flag in the same cycle within reach, as well as a new edge landing between a high-word read and the following low-word read.

// File: rtl/trig_stamp_pkg.sv
package trig_stamp_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned POL_LSB      = 8;
  localparam int unsigned EVT_LSB      = 24;
  localparam int unsigned OFS_CTRL     = 0;
  localparam int unsigned OFS_EVENT    = 1;
  localparam int unsigned OFS_MASK     = 2;
  localparam int unsigned OFS_CAP_BASE = 3;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  input  logic fall_sel,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;
  logic              synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= '0;
      last_lvl <= 1'b0;
    end else begin
      chain    <= {chain[STAGES-2:0], async_in};
      last_lvl <= chain[STAGES-1];
    end
  end

  assign synced     = chain[STAGES-1];
  assign edge_pulse = fall_sel ? (last_lvl & ~synced) : (synced & ~last_lvl);

  AST_RISE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (edge_pulse && !fall_sel) |=> !(edge_pulse && !fall_sel)); // R3
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [TIME_W-1:0] time_now,
  input  logic              hi_read,
  output logic [WORD_W-1:0] word_hi,
  output logic [WORD_W-1:0] word_lo_held
);
  logic [TIME_W-1:0] snap;
  logic [WORD_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= '0;
      lo_hold <= '0;
    end else begin
      if (stb)     snap    <= time_now;
      if (hi_read) lo_hold <= snap[WORD_W-1:0];
    end
  end

  assign word_hi      = snap[TIME_W-1:WORD_W];
  assign word_lo_held = lo_hold;

  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    stb |=> (snap == $past(time_now))); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(snap)); // R2
  AST_LO_PAIR: assert property (@(posedge clk) disable iff (rst)
    hi_read |=> (lo_hold == $past(snap[WORD_W-1:0]))); // R8
endmodule

// File: rtl/trig_event_ctrl.sv
module trig_event_ctrl #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_vec,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_vec,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_vec,
  output logic [NCH-1:0] evt,
  output logic [NCH-1:0] mask,
  output logic           irq
);
  logic [NCH-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt  <= '0;
      mask <= '0;
    end else begin
      evt <= (evt & ~clr_eff) | set_vec;
      if (mask_we) mask <= mask_vec;
    end
  end

  assign irq = |(evt & mask);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && !(clr_we && clr_vec[i])) |=> evt[i]); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> evt[i]); // R5
  end
endmodule

// File: rtl/trig_stamp_unit.sv
module trig_stamp_unit
  import trig_stamp_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned TIME_W      = 64,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = $clog2(OFS_CAP_BASE + 2 * NCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    trig_in,
  input  logic [TIME_W-1:0] time_now,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_EVENT = ADDR_W'(OFS_EVENT);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

  logic [NCH-1:0]    pol;
  logic [NCH-1:0]    edge_hit;
  logic [NCH-1:0]    hi_rd;
  logic [NCH-1:0]    evt;
  logic [NCH-1:0]    mask;
  logic [WORD_W-1:0] cap_hi [NCH];
  logic [WORD_W-1:0] cap_lo [NCH];
  logic              ctrl_we;
  logic              unused_wdata;

  assign ctrl_we      = cfg_wr_en && (cfg_addr == A_CTRL);
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst)          pol <= '0;
    else if (ctrl_we) pol <= cfg_wdata[POL_LSB +: NCH];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hi_rd[c] = cfg_rd_en && (cfg_addr == ADDR_W'(OFS_CAP_BASE + 2 * c));

    trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(trig_in[c]), .fall_sel(pol[c]),
      .edge_pulse(edge_hit[c])
    );

    trig_capture #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_cap (
      .clk(clk), .rst(rst), .stb(edge_hit[c]), .time_now(time_now),
      .hi_read(hi_rd[c]), .word_hi(cap_hi[c]), .word_lo_held(cap_lo[c])
    );
  end

  trig_event_ctrl #(.NCH(NCH)) u_evt (
    .clk(clk), .rst(rst), .set_vec(edge_hit),
    .clr_we(cfg_wr_en && (cfg_addr == A_EVENT)),
    .clr_vec(cfg_wdata[EVT_LSB +: NCH]),
    .mask_we(cfg_wr_en && (cfg_addr == A_MASK)),
    .mask_vec(cfg_wdata[EVT_LSB +: NCH]),
    .evt(evt), .mask(mask), .irq(irq)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_CTRL)  cfg_rdata[POL_LSB +: NCH] = pol;
    if (cfg_addr == A_EVENT) cfg_rdata[EVT_LSB +: NCH] = evt;
    if (cfg_addr == A_MASK)  cfg_rdata[EVT_LSB +: NCH] = mask;
    for (int c = 0; c < NCH; c++) begin
      if (cfg_addr == ADDR_W'(OFS_CAP_BASE + 2 * c))     cfg_rdata = cap_hi[c];
      if (cfg_addr == ADDR_W'(OFS_CAP_BASE + 2 * c + 1)) cfg_rdata = cap_lo[c];
    end
  end

  AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(pol)); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (evt == '0) |-> !irq); // R6
endmodule

// File: tb/trig_stamp_unit_bench.sv
module trig_stamp_unit_bench;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  trig_in = '0;
  logic [63:0] time_now = 64'h0000_0012_FFFF_FFC0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;

  always #10 clk = ~clk;

  trig_stamp_unit u_trig_stamp_unit (
    .clk(clk), .rst(rst), .trig_in(trig_in), .time_now(time_now),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit [1:0]  m_a, m_b, m_c, m_pol, m_ev, m_mask;
  bit [63:0] m_cap [NCH];
  bit [31:0] m_lo [NCH];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] exp_rd(bit [2:0] a);
    case (a)
      3'd0: return {22'd0, m_pol, 8'd0};
      3'd1: return {6'd0, m_ev, 24'd0};
      3'd2: return {6'd0, m_mask, 24'd0};
      3'd3: return m_cap[0][63:32];
      3'd4: return m_lo[0];
      3'd5: return m_cap[1][63:32];
      3'd6: return m_lo[1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(bit [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3, 3'd5: return "R2";
      3'd4, 3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_step();
    bit [1:0] hit;
    if (rst) begin
      m_a = 0; m_b = 0; m_c = 0; m_pol = 0; m_ev = 0; m_mask = 0;
      for (int c = 0; c < NCH; c++) begin m_cap[c] = 0; m_lo[c] = 0; end
      return;
    end
    for (int c = 0; c < NCH; c++)
      hit[c] = m_pol[c] ? (m_c[c] && !m_b[c]) : (m_b[c] && !m_c[c]);
    for (int c = 0; c < NCH; c++) begin
      if (cfg_rd_en && cfg_addr == 3'(3 + 2 * c)) m_lo[c] = m_cap[c][31:0];
      if (hit[c]) m_cap[c] = time_now;
    end
    if (cfg_wr_en && cfg_addr == 3'd1) m_ev = m_ev & ~cfg_wdata[25:24];
    m_ev = m_ev | hit;
    if (cfg_wr_en && cfg_addr == 3'd2) m_mask = cfg_wdata[25:24];
    if (cfg_wr_en && cfg_addr == 3'd0) m_pol = cfg_wdata[9:8];
    m_c = m_b; m_b = m_a; m_a = trig_in;
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    chk(tag_of(cfg_addr), cfg_rdata, exp_rd(cfg_addr));
    chk("R6", irq, |(m_ev & m_mask));
    time_now = time_now + 64'd3;
  endtask

  task automatic cycs(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_wr_en = 0;
  endtask

  task automatic rd_at(bit [2:0] a, output logic [31:0] v);
    cfg_addr = a;
    cyc();
    v = cfg_rdata;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, first_lo, first_hi;
    cycs(3);
    rst = 0;
    for (int a = 0; a < 8; a++) begin
      rd_at(3'(a), v);
      chk("R1", v, 0);
    end
    chk("R1", irq, 0);

    wr(3'd2, 32'h0300_0000);
    trig_in[0] = 1; cycs(4);
    rd_at(3'd1, v); chk("R4", v, 32'h0100_0000);
    chk("R6", irq, 1);
    cfg_rd_en = 1; cfg_addr = 3'd3; cyc(); cfg_rd_en = 0;
    first_hi = cfg_rdata;
    rd_at(3'd4, first_lo); chk("R8", first_lo, m_cap[0][31:0]);

    wr(3'd1, 32'h0000_0000);
    rd_at(3'd1, v); chk("R5", v, 32'h0100_0000);
    wr(3'd1, 32'h0100_0000);
    rd_at(3'd1, v); chk("R5", v, 0);
    trig_in[0] = 0; cycs(4);
    rd_at(3'd1, v); chk("R3", v, 0);

    wr(3'd0, 32'h0000_0200);
    trig_in[1] = 1; cycs(4);
    rd_at(3'd1, v); chk("R3", v, 0);
    trig_in[1] = 0; cycs(4);
    rd_at(3'd1, v); chk("R3", v, 32'h0200_0000);

    trig_in[0] = 1; cycs(4);
    trig_in[0] = 0; cycs(2);
    trig_in[0] = 1; cycs(4);
    cfg_rd_en = 1; cfg_addr = 3'd3; cyc(); cfg_rd_en = 0;
    rd_at(3'd4, v);
    chk("R7", (v != first_lo) ? 1 : 0, 1);
    rd_at(3'd1, v); chk("R7", v, 32'h0300_0000);

    wr(3'd2, 32'h0);
    chk("R6", irq, 0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_at(3'd0, v); chk("R9", v, 32'h0000_0300);
    rd_at(3'd7, v); chk("R9", v, 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      if (r[2:0] == 0) trig_in[0] = ~trig_in[0];
      if (r[5:3] == 0) trig_in[1] = ~trig_in[1];
      cfg_addr  = r[8:6];
      cfg_rd_en = r[9];
      cfg_wr_en = (r[13:10] == 0) && (r[8:6] <= 3'd2);
      cfg_wdata = {6'd0, r[15:14], 14'd0, r[17:16], 8'd0};
      cyc();
    end
    cfg_wr_en = 0; cfg_rd_en = 0;
    cycs(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule